// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is a small processor that completes one instruction on every clock edge. Each instruction is a single byte. The high nibble selects the operation class and the low nibble carries either a register index or a 4-bit jump target. The program is a 16-byte image. It is given to the core as a parameter and is read through a 4-bit program counter that wraps from 15 back to 0.

Architectural state is the program counter, an 8-bit accumulator, a carry/borrow flag, an extension register that receives the upper half of products, sixteen 8-bit general registers and a halted bit. Arithmetic and logic work is done by a separate ALU. Decoding is handled by its own combinational unit. Sequencing and state updates stay in the top level. The core has no data inputs. Its state is visible only through debug outputs, so a program shows its behaviour through the PC, accumulator, flag, extension and halted values after each instruction.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the PC, accumulator, flag, extension register, all sixteen general registers and the halted bit. The outputs show zero on the cycle after the reset edge.
- R2: Every instruction except a branch, a jump or the halt byte advances the PC by one, and the PC wraps from 15 to 0.
- R3: High nibble 9 loads the accumulator from register Ri, where i is the low nibble. High nibble A stores the accumulator into Ri and leaves the accumulator and flag unchanged.
- R4: High nibble 1 adds Ri to the accumulator and sets the flag to the carry out of bit 7. High nibble 2 subtracts Ri from the accumulator and sets the flag to 1 exactly when the accumulator was below Ri (unsigned).
- R5: High nibble 3 multiplies the accumulator by Ri. The low byte of the 16-bit product goes to the accumulator and the high byte to the extension register, and the flag is left alone.
- R6: High nibbles 5 and 6 perform bitwise AND and XOR of the accumulator with Ri and leave the flag and extension unchanged.
- R7: High nibble 7 compares: the flag becomes 1 when the accumulator is below Ri (unsigned), else 0, and the accumulator is unchanged.
- R8: Bytes 01 to 05 operate on the accumulator alone and do not touch the flag. They are, in order: shift left with zero fill, shift right with zero fill, rotate right, rotate left, and shift right keeping bit 7.
- R9: Byte 06 increments the accumulator and sets the flag to 1 only when it wraps from FF to 00. Byte 07 decrements it and sets the flag to 1 only when it wraps from 00 to FF.
- R10: High nibble 8 loads the PC with the low nibble when the flag is 1, and otherwise advances the PC by one.
- R11: High nibble B loads the PC with the low nibble unconditionally.
- R12: Byte FF sets the halted bit on the next edge and keeps the PC on the halt byte. From then until reset, the PC, accumulator, flag, extension and registers do not change.
- R13: Byte 00, bytes 08 to 0F, high nibble 4, high nibbles C to E, and high nibble F with a low nibble other than F all change nothing except advancing the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 4 | Current program counter |
| acc_o | output | 8 | Accumulator |
| cb_o | output | 1 | Carry/borrow flag |
| ext_o | output | 8 | Extension register (upper product byte) |
| halted_o | output | 1 | High once the halt byte has executed |

## Verification
The assertions check on every cycle how the program counter moves: single steps, taken and fall-through branches, and jumps. They also check that the halt byte freezes all visible state, that flag-neutral classes (multiply, logic, shifts, rotates, stores) keep the flag, that compare and store keep the accumulator, and that no-op encodings keep all data state. The arithmetic values themselves can only be shown by the bench's programs, which compare against an independent instruction model. These include carries and borrows at FF and 00, rotation and sign-fill results, the split of a product between accumulator and extension, and register file contents read back after stores and after a second reset.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int INSTR_W = 8;
    localparam int FIELD_W = 4;

    // operation classes carried in the high nibble
    typedef enum logic [3:0] {
        CLS_SYS = 4'h0,
        CLS_ADD = 4'h1,
        CLS_SUB = 4'h2,
        CLS_MUL = 4'h3,
        CLS_AND = 4'h5,
        CLS_XOR = 4'h6,
        CLS_CMP = 4'h7,
        CLS_BRC = 4'h8,
        CLS_LDA = 4'h9,
        CLS_STA = 4'hA,
        CLS_JMP = 4'hB,
        CLS_HLT = 4'hF
    } cls_e;

    // low-nibble selectors inside class 0
    localparam logic [3:0] SYS_SHL = 4'h1;
    localparam logic [3:0] SYS_SHR = 4'h2;
    localparam logic [3:0] SYS_ROR = 4'h3;
    localparam logic [3:0] SYS_ROL = 4'h4;
    localparam logic [3:0] SYS_SRA = 4'h5;
    localparam logic [3:0] SYS_INC = 4'h6;
    localparam logic [3:0] SYS_DEC = 4'h7;

    typedef enum logic [3:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_AND,
        ALU_XOR,
        ALU_SHL,
        ALU_SHR,
        ALU_ROR,
        ALU_ROL,
        ALU_SRA,
        ALU_INC,
        ALU_DEC
    } alu_op_e;

    typedef enum logic [1:0] {
        PC_STEP,
        PC_LOAD,
        PC_HOLD
    } pc_sel_e;

    typedef struct packed {
        alu_op_e op;
        logic    acc_we;
        logic    cb_we;
        logic    ext_we;
        logic    reg_we;
        pc_sel_e pc_sel;
        logic    halt_set;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c.op       = ALU_PASS;
        c.acc_we   = 1'b0;
        c.cb_we    = 1'b0;
        c.ext_we   = 1'b0;
        c.reg_we   = 1'b0;
        c.pc_sel   = PC_STEP;
        c.halt_set = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_core_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               cb,
    input  logic               halted,
    output ctrl_t              ctrl
);

    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;

    assign hi = instr[INSTR_W-1 -: FIELD_W];
    assign lo = instr[FIELD_W-1:0];

    always_comb begin
        ctrl = ctrl_idle();
        if (halted) begin
            ctrl.pc_sel = PC_HOLD;
        end else begin
            case (hi)
                CLS_SYS: begin
                    case (lo)
                        SYS_SHL: begin ctrl.op = ALU_SHL; ctrl.acc_we = 1'b1; end
                        SYS_SHR: begin ctrl.op = ALU_SHR; ctrl.acc_we = 1'b1; end
                        SYS_ROR: begin ctrl.op = ALU_ROR; ctrl.acc_we = 1'b1; end
                        SYS_ROL: begin ctrl.op = ALU_ROL; ctrl.acc_we = 1'b1; end
                        SYS_SRA: begin ctrl.op = ALU_SRA; ctrl.acc_we = 1'b1; end
                        SYS_INC: begin
                            ctrl.op = ALU_INC; ctrl.acc_we = 1'b1; ctrl.cb_we = 1'b1;
                        end
                        SYS_DEC: begin
                            ctrl.op = ALU_DEC; ctrl.acc_we = 1'b1; ctrl.cb_we = 1'b1;
                        end
                        default: ;
                    endcase
                end
                CLS_ADD: begin ctrl.op = ALU_ADD; ctrl.acc_we = 1'b1; ctrl.cb_we = 1'b1; end
                CLS_SUB: begin ctrl.op = ALU_SUB; ctrl.acc_we = 1'b1; ctrl.cb_we = 1'b1; end
                CLS_MUL: begin ctrl.op = ALU_MUL; ctrl.acc_we = 1'b1; ctrl.ext_we = 1'b1; end
                CLS_AND: begin ctrl.op = ALU_AND; ctrl.acc_we = 1'b1; end
                CLS_XOR: begin ctrl.op = ALU_XOR; ctrl.acc_we = 1'b1; end
                CLS_CMP: begin ctrl.op = ALU_SUB; ctrl.cb_we = 1'b1; end
                CLS_BRC: begin
                    if (cb) ctrl.pc_sel = PC_LOAD;
                end
                CLS_LDA: begin ctrl.op = ALU_PASS; ctrl.acc_we = 1'b1; end
                CLS_STA: ctrl.reg_we = 1'b1;
                CLS_JMP: ctrl.pc_sel = PC_LOAD;
                CLS_HLT: begin
                    if (lo == '1) begin
                        ctrl.halt_set = 1'b1;
                        ctrl.pc_sel   = PC_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] res_hi,
    output logic              flag
);

    localparam int WIDE_W = 2 * DATA_W;

    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic [DATA_W:0]   inc_w;
    logic [DATA_W:0]   dec_w;
    logic [WIDE_W-1:0] prod_w;

    assign sum_w  = {1'b0, a} + {1'b0, b};
    assign dif_w  = {1'b0, a} - {1'b0, b};
    assign inc_w  = {1'b0, a} + (DATA_W+1)'(1);
    assign dec_w  = {1'b0, a} - (DATA_W+1)'(1);
    assign prod_w = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

    assign res_hi = prod_w[WIDE_W-1:DATA_W];

    always_comb begin
        res  = a;
        flag = 1'b0;
        case (op)
            ALU_PASS: res = b;
            ALU_ADD:  begin res = sum_w[DATA_W-1:0]; flag = sum_w[DATA_W]; end
            ALU_SUB:  begin res = dif_w[DATA_W-1:0]; flag = dif_w[DATA_W]; end
            ALU_MUL:  res = prod_w[DATA_W-1:0];
            ALU_AND:  res = a & b;
            ALU_XOR:  res = a ^ b;
            ALU_SHL:  res = {a[DATA_W-2:0], 1'b0};
            ALU_SHR:  res = {1'b0, a[DATA_W-1:1]};
            ALU_ROR:  res = {a[0], a[DATA_W-1:1]};
            ALU_ROL:  res = {a[DATA_W-2:0], a[DATA_W-1]};
            ALU_SRA:  res = {a[DATA_W-1], a[DATA_W-1:1]};
            ALU_INC:  begin res = inc_w[DATA_W-1:0]; flag = inc_w[DATA_W]; end
            ALU_DEC:  begin res = dec_w[DATA_W-1:0]; flag = dec_w[DATA_W]; end
            default:  res = a;
        endcase
    end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int NREG = 2 ** IDX_W;

    logic [DATA_W-1:0] regs [NREG];
    logic [NREG-1:0]   wsel;

    for (genvar i = 0; i < NREG; i++) begin : g_wsel
        assign wsel[i] = we && (waddr == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (rst)          regs[k] <= '0;
            else if (wsel[k]) regs[k] <= wdata;
        end
    end

    assign rdata = regs[raddr];

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [INSTR_W-1:0] PROG [2**FIELD_W] = '{default: '0}
) (
    input  logic              clk,
    input  logic              rst,
    output logic [FIELD_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              cb_o,
    output logic [DATA_W-1:0] ext_o,
    output logic              halted_o
);

    logic [FIELD_W-1:0] pc_q;
    logic [DATA_W-1:0]  acc_q;
    logic               cb_q;
    logic [DATA_W-1:0]  ext_q;
    logic               halted_q;

    logic [INSTR_W-1:0] cur_instr;
    logic [FIELD_W-1:0] opnd;
    ctrl_t              ctrl;
    logic [DATA_W-1:0]  rf_rdata;
    logic [DATA_W-1:0]  alu_res;
    logic [DATA_W-1:0]  alu_hi;
    logic               alu_flag;
    logic [FIELD_W-1:0] pc_next;

    assign cur_instr = PROG[pc_q];
    assign opnd      = cur_instr[FIELD_W-1:0];

    acc_decode u_dec (
        .instr  (cur_instr),
        .cb     (cb_q),
        .halted (halted_q),
        .ctrl   (ctrl)
    );

    acc_regfile #(
        .DATA_W (DATA_W),
        .IDX_W  (FIELD_W)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.reg_we),
        .waddr (opnd),
        .wdata (acc_q),
        .raddr (opnd),
        .rdata (rf_rdata)
    );

    acc_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (ctrl.op),
        .a      (acc_q),
        .b      (rf_rdata),
        .res    (alu_res),
        .res_hi (alu_hi),
        .flag   (alu_flag)
    );

    always_comb begin
        case (ctrl.pc_sel)
            PC_LOAD: pc_next = opnd;
            PC_HOLD: pc_next = pc_q;
            default: pc_next = pc_q + FIELD_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            acc_q    <= '0;
            cb_q     <= 1'b0;
            ext_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            pc_q <= pc_next;
            if (ctrl.acc_we)   acc_q    <= alu_res;
            if (ctrl.cb_we)    cb_q     <= alu_flag;
            if (ctrl.ext_we)   ext_q    <= alu_hi;
            if (ctrl.halt_set) halted_q <= 1'b1;
        end
    end

    assign pc_o     = pc_q;
    assign acc_o    = acc_q;
    assign cb_o     = cb_q;
    assign ext_o    = ext_q;
    assign halted_o = halted_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [FIELD_W-1:0] pc_o,
    input logic [DATA_W-1:0]  acc_o,
    input logic               cb_o,
    input logic [DATA_W-1:0]  ext_o,
    input logic               halted_o,
    input logic [INSTR_W-1:0] instr
);

    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
    logic               live;
    logic               is_ctl;
    logic               is_shift;
    logic               is_nop;

    assign hi       = instr[INSTR_W-1 -: FIELD_W];
    assign lo       = instr[FIELD_W-1:0];
    assign live     = !halted_o;
    assign is_ctl   = (hi == 4'h8) || (hi == 4'hB) || (instr == 8'hFF);
    assign is_shift = (hi == 4'h0) && (lo >= 4'h1) && (lo <= 4'h5);
    assign is_nop   = (instr == 8'h00) || ((hi == 4'h0) && lo[3]) || (hi == 4'h4)
                    || (hi == 4'hC) || (hi == 4'hD) || (hi == 4'hE)
                    || ((hi == 4'hF) && (lo != 4'hF));

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc_o == '0) && (acc_o == '0) && !cb_o && (ext_o == '0) && !halted_o);

    // R2
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (live && !is_ctl) |=> pc_o == ($past(pc_o) + 4'd1));

    // R3
    p_store_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (live && hi == 4'hA) |=> $stable(acc_o) && $stable(cb_o) && $stable(ext_o));

    // R5
    p_mul_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (live && hi == 4'h3) |=> $stable(cb_o));

    // R6
    p_logic_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (live && (hi == 4'h5 || hi == 4'h6)) |=> $stable(cb_o) && $stable(ext_o));

    // R7
    p_cmp_acc_r7: assert property (@(posedge clk) disable iff (rst)
        (live && hi == 4'h7) |=> $stable(acc_o) && $stable(ext_o));

    // R8
    p_shift_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (live && is_shift) |=> $stable(cb_o) && $stable(ext_o));

    // R10
    p_branch_taken_r10: assert property (@(posedge clk) disable iff (rst)
        (live && hi == 4'h8 && cb_o) |=> pc_o == $past(lo));

    p_branch_fall_r10: assert property (@(posedge clk) disable iff (rst)
        (live && hi == 4'h8 && !cb_o) |=> pc_o == ($past(pc_o) + 4'd1));

    // R11
    p_jump_r11: assert property (@(posedge clk) disable iff (rst)
        (live && hi == 4'hB) |=> pc_o == $past(lo));

    // R12
    p_halt_enter_r12: assert property (@(posedge clk) disable iff (rst)
        (live && instr == 8'hFF) |=> halted_o && $stable(pc_o) && $stable(acc_o) && $stable(cb_o));

    p_halt_freeze_r12: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> halted_o && $stable(pc_o) && $stable(acc_o) && $stable(cb_o) && $stable(ext_o));

    // R13
    p_nop_keeps_r13: assert property (@(posedge clk) disable iff (rst)
        (live && is_nop) |=> $stable(acc_o) && $stable(cb_o) && $stable(ext_o) && !halted_o);

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc_o     (pc_o),
    .acc_o    (acc_o),
    .cb_o     (cb_o),
    .ext_o    (ext_o),
    .halted_o (halted_o),
    .instr    (cur_instr)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;

    localparam int NP = 4;

    // arithmetic, multiply split, logic, wrap 15->0
    localparam logic [7:0] PROG_A [16] = '{
        8'h06, 8'h01, 8'h01, 8'h06, 8'hA1, 8'h02, 8'h11, 8'h31,
        8'h31, 8'h31, 8'h21, 8'h71, 8'h61, 8'h51, 8'h07, 8'h07};
    // shifts, rotates, sign fill, carries at FF/00, halt
    localparam logic [7:0] PROG_B [16] = '{
        8'h07, 8'h03, 8'h05, 8'h02, 8'h04, 8'h03, 8'hA2, 8'h12,
        8'h01, 8'h05, 8'h06, 8'h06, 8'h92, 8'h22, 8'h12, 8'hFF};
    // undefined encodings, branches both ways, jump, halt
    localparam logic [7:0] PROG_C [16] = '{
        8'h00, 8'h08, 8'h4F, 8'hC3, 8'hFE, 8'h84, 8'h07, 8'h8A,
        8'h06, 8'h06, 8'hA5, 8'h75, 8'h06, 8'h8F, 8'hFF, 8'hBE};
    // register file moves, compare borrow, reset of registers
    localparam logic [7:0] PROG_D [16] = '{
        8'h06, 8'hAF, 8'h06, 8'hA0, 8'h9F, 8'h70, 8'h89, 8'h06,
        8'h06, 8'h3F, 8'h9E, 8'h1F, 8'h60, 8'hAE, 8'h9E, 8'h0F};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [3:0] o_pc  [NP];
    logic [7:0] o_acc [NP];
    logic       o_cb  [NP];
    logic [7:0] o_ext [NP];
    logic       o_hlt [NP];

    acc_core #(.PROG(PROG_A)) u_dut (
        .clk(clk), .rst(rst), .pc_o(o_pc[0]), .acc_o(o_acc[0]),
        .cb_o(o_cb[0]), .ext_o(o_ext[0]), .halted_o(o_hlt[0]));
    acc_core #(.PROG(PROG_B)) u_dut_b (
        .clk(clk), .rst(rst), .pc_o(o_pc[1]), .acc_o(o_acc[1]),
        .cb_o(o_cb[1]), .ext_o(o_ext[1]), .halted_o(o_hlt[1]));
    acc_core #(.PROG(PROG_C)) u_dut_c (
        .clk(clk), .rst(rst), .pc_o(o_pc[2]), .acc_o(o_acc[2]),
        .cb_o(o_cb[2]), .ext_o(o_ext[2]), .halted_o(o_hlt[2]));
    acc_core #(.PROG(PROG_D)) u_dut_d (
        .clk(clk), .rst(rst), .pc_o(o_pc[3]), .acc_o(o_acc[3]),
        .cb_o(o_cb[3]), .ext_o(o_ext[3]), .halted_o(o_hlt[3]));

    int total = 0;
    int bad   = 0;

    typedef struct {
        int         prog;
        int         tag;
        logic [3:0] pc;
        logic [7:0] acc;
        logic       cb;
        logic [7:0] ext;
        logic       hlt;
    } exp_t;

    exp_t sb [$];

    // independent instruction model
    logic [7:0] progs  [NP][16];
    logic [3:0] m_pc   [NP];
    logic [7:0] m_acc  [NP];
    logic       m_cb   [NP];
    logic [7:0] m_ext  [NP];
    logic       m_hlt  [NP];
    logic [7:0] m_regs [NP][16];

    function automatic string tag_name(int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            11: return "R11";
            12: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_pc[p] = '0; m_acc[p] = '0; m_cb[p] = 1'b0; m_ext[p] = '0; m_hlt[p] = 1'b0;
            for (int r = 0; r < 16; r++) m_regs[p][r] = '0;
        end
    endtask

    task automatic model_step(input int p, output int tag);
        logic [7:0] ins, a, r;
        logic [3:0] hi, lo, npc;
        logic [8:0]  w9;
        logic [15:0] w16;
        ins = progs[p][m_pc[p]];
        hi = ins[7:4]; lo = ins[3:0];
        a = m_acc[p]; r = m_regs[p][lo];
        npc = m_pc[p] + 4'd1;
        tag = 13;
        if (m_hlt[p]) begin
            tag = 12;
            return;
        end
        case (hi)
            4'h0: begin
                case (lo)
                    4'h1: begin a = a << 1; tag = 8; end
                    4'h2: begin a = a >> 1; tag = 8; end
                    4'h3: begin a = {a[0], a[7:1]}; tag = 8; end
                    4'h4: begin a = {a[6:0], a[7]}; tag = 8; end
                    4'h5: begin a = {a[7], a[7:1]}; tag = 8; end
                    4'h6: begin m_cb[p] = (a == 8'hFF); a = a + 8'd1; tag = 9; end
                    4'h7: begin m_cb[p] = (a == 8'h00); a = a - 8'd1; tag = 9; end
                    default: tag = 13;
                endcase
            end
            4'h1: begin w9 = {1'b0, a} + {1'b0, r}; a = w9[7:0]; m_cb[p] = w9[8]; tag = 4; end
            4'h2: begin m_cb[p] = (a < r); a = a - r; tag = 4; end
            4'h3: begin w16 = {8'h00, a} * {8'h00, r}; a = w16[7:0]; m_ext[p] = w16[15:8]; tag = 5; end
            4'h5: begin a = a & r; tag = 6; end
            4'h6: begin a = a ^ r; tag = 6; end
            4'h7: begin m_cb[p] = (a < r); tag = 7; end
            4'h8: begin if (m_cb[p]) npc = lo; tag = 10; end
            4'h9: begin a = r; tag = 3; end
            4'hA: begin m_regs[p][lo] = a; tag = 3; end
            4'hB: begin npc = lo; tag = 11; end
            4'hF: begin
                if (lo == 4'hF) begin m_hlt[p] = 1'b1; npc = m_pc[p]; tag = 12; end
            end
            default: tag = 13;
        endcase
        if (m_pc[p] == 4'hF && tag != 10 && tag != 11 && tag != 12) tag = 2;
        m_acc[p] = a;
        m_pc[p]  = npc;
    endtask

    task automatic drive(input int n);
        for (int k = 0; k < n; k++) begin
            for (int p = 0; p < NP; p++) begin
                exp_t e;
                int t;
                model_step(p, t);
                e.prog = p; e.tag = t; e.pc = m_pc[p]; e.acc = m_acc[p];
                e.cb = m_cb[p]; e.ext = m_ext[p]; e.hlt = m_hlt[p];
                sb.push_back(e);
            end
            @(negedge clk);
        end
    endtask

    // monitor: compare each produced state with the queued expectation
    always @(posedge clk) begin
        #2;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (o_pc[e.prog] !== e.pc || o_acc[e.prog] !== e.acc || o_cb[e.prog] !== e.cb
                || o_ext[e.prog] !== e.ext || o_hlt[e.prog] !== e.hlt) begin
                bad++;
                $display("FAIL %s prog%0d: got pc=%h acc=%h cb=%b ext=%h hlt=%b exp pc=%h acc=%h cb=%b ext=%h hlt=%b",
                         tag_name(e.tag), e.prog, o_pc[e.prog], o_acc[e.prog], o_cb[e.prog],
                         o_ext[e.prog], o_hlt[e.prog], e.pc, e.acc, e.cb, e.ext, e.hlt);
            end
        end
    end

    // R1: reset state on every instance
    task automatic check_reset_r1();
        for (int p = 0; p < NP; p++) begin
            total++;
            if (o_pc[p] !== 4'h0 || o_acc[p] !== 8'h00 || o_cb[p] !== 1'b0
                || o_ext[p] !== 8'h00 || o_hlt[p] !== 1'b0) begin
                bad++;
                $display("FAIL R1 prog%0d: got pc=%h acc=%h cb=%b ext=%h hlt=%b exp all zero",
                         p, o_pc[p], o_acc[p], o_cb[p], o_ext[p], o_hlt[p]);
            end
        end
    endtask

    initial begin
        progs[0] = PROG_A; progs[1] = PROG_B; progs[2] = PROG_C; progs[3] = PROG_D;
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_r1();
        rst = 1'b0;
        drive(60);
        // second reset: registers written during the first run must read as zero again
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check_reset_r1();
        rst = 1'b0;
        drive(30);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 5000);
        bad++;
        total++;
        $display("FAIL watchdog: got no completion exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule